// File: doc/BRIEF.md
# Byte-Addressed Register Slave on a Mode-3 Serial Port

This block sits between a four-wire serial port and a register file that lives in the system clock domain. The host runs the port with the clock idling high. Each transfer is a 16-bit word, sent most significant bit first. The block turns each completed word into one transaction on a simple register bus: either a byte write, or a word read.

The block resynchronizes the serial clock, chip select and data input into the system clock. It then acts on their edges, so the serial clock must run at least four times slower than the system clock. A read is pipelined: the requested 16-bit word comes back during the following transfer, and that transfer can carry a new request of its own. A single chip-select window may hold several transfers back to back. If chip select is released part-way through a transfer, a sticky error flag is raised.

Each 16-bit register occupies two byte addresses. The low byte sits at the even address and the high byte at the next odd address. A write changes only the byte that is addressed. The read strobe lets the register side attach side effects to a read, such as advancing a buffer index.

Top module: `spi_byte_regslave`

## Requirements
- R1: A transfer word is taken most significant bit first on rising serial clock edges while chip select is low. Bit 15 selects the operation (1 = write, 0 = read), bits 14:8 are the byte address and bits 7:0 are the data byte.
- R2: A write word produces a single-cycle `reg_we`. During that cycle `reg_addr` carries the byte address and `reg_wdata` carries the data byte. The pulse arrives on the third system clock edge after the 16th rising serial clock edge.
- R3: A read word produces a single-cycle `reg_re`, with `reg_addr` set to the byte address, at the same point in time as R2. The data byte of a read word is ignored: no write takes place and no register changes. `reg_we` and `reg_re` are never high together.
- R4: The word on `reg_rdata` during the `reg_re` cycle is shifted out on `miso` during the next transfer, most significant bit first. A new bit appears after each falling serial clock edge.
- R5: After reset, and after any write word, the following transfer shifts out 0x0000.
- R6: Transfers placed back to back inside one chip-select window behave exactly as separate transfers would, including the read pipeline.
- R7: `miso_oe` is low whenever `cs_n` is high and high whenever `cs_n` is low; `miso` is only meaningful while `miso_oe` is high.
- R8: If `cs_n` rises after a count of rising serial clock edges that is not a multiple of 16, `comm_err` is set and stays set until reset. The incomplete word produces no strobe and leaves the pending read word unchanged. The next chip-select window starts a fresh word.
- R9: `reg_addr` is the full 7-bit byte address. The register side returns the whole 16-bit word at `reg_addr` divided by 2, so a read at an odd address returns the same word as the even address below it.
- R10: In reset, `reg_we`, `reg_re` and `comm_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| mosi | input | 1 | Serial data from host |
| miso | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for miso (high-impedance when low) |
| reg_addr | output | 7 | Byte address of the current transaction |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_re | output | 1 | Single-cycle read strobe |
| reg_rdata | input | 16 | Word at reg_addr divided by 2, sampled during reg_re |
| comm_err | output | 1 | Sticky framing error flag |

## Verification
Each serial input passes through two synchronizer stages and one edge-history stage, so a bus strobe is due on exactly the third system clock edge after the 16th rising serial clock edge is driven. The bench's reference model stamps every expected strobe with that cycle. On every clock it compares the strobes against this stamp, along with address, data and operation. Read data is due one full transfer later, and the bench samples `miso` just before each rising serial clock edge. The sticky flag is checked a few clocks after chip select rises, because it takes three clock edges to register.

// File: rtl/spi_byte_regslave.sv
module spi_byte_regslave #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                sclk,
  input  logic                mosi,
  output logic                miso,
  output logic                miso_oe,
  output logic [ADDR_W-1:0]   reg_addr,
  output logic [DATA_W-1:0]   reg_wdata,
  output logic                reg_we,
  output logic                reg_re,
  input  logic [2*DATA_W-1:0] reg_rdata,
  output logic                comm_err
);
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
  localparam int REG_W      = 2 * DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  logic [2:0]            sck_q, csn_q;
  logic [1:0]            di_q;
  logic [CNT_W-1:0]      cnt;
  logic [FRAME_BITS-2:0] rx;
  logic [REG_W-1:0]      hold;
  logic [REG_W-2:0]      tx;
  logic                  miso_q;

  wire active   = ~csn_q[1];
  wire sck_rise = active &  sck_q[1] & ~sck_q[2];
  wire sck_fall = active & ~sck_q[1] &  sck_q[2];
  wire cs_end   = csn_q[1] & ~csn_q[2];
  wire [FRAME_BITS-1:0] word = {rx, di_q[1]};
  wire last     = sck_rise && (cnt == CNT_W'(FRAME_BITS-1));

  assign miso    = miso_q;
  assign miso_oe = ~cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= '1;
      csn_q <= '1;
      di_q  <= '0;
    end else begin
      sck_q <= {sck_q[1:0], sclk};
      csn_q <= {csn_q[1:0], cs_n};
      di_q  <= {di_q[0], mosi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      rx       <= '0;
      comm_err <= 1'b0;
    end else begin
      if (!active) cnt <= '0;
      else if (sck_rise) begin
        cnt <= last ? '0 : cnt + 1'b1;
        rx  <= word[FRAME_BITS-2:0];
      end
      if (cs_end && cnt != '0) comm_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
    end else begin
      reg_we <= last &  word[FRAME_BITS-1];
      reg_re <= last & ~word[FRAME_BITS-1];
      if (last) begin
        reg_addr  <= word[FRAME_BITS-2:DATA_W];
        reg_wdata <= word[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold   <= '0;
      tx     <= '0;
      miso_q <= 1'b0;
    end else begin
      if (reg_re)      hold <= reg_rdata;
      else if (reg_we) hold <= '0;
      if (sck_fall) begin
        if (cnt == '0) {miso_q, tx} <= hold;
        else           {miso_q, tx} <= {tx, 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_byte_regslave_chk.sv
module spi_byte_regslave_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_we,
  input logic reg_re,
  input logic comm_err
);
  a_r3_we_re_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_re));
  a_r2_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);
  a_r3_re_single: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !reg_re);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    comm_err |=> comm_err);
endmodule

bind spi_byte_regslave spi_byte_regslave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .comm_err(comm_err)
);

// File: tb/spi_byte_regslave_bench.sv
module spi_byte_regslave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 1, mosi = 0;
  logic miso, miso_oe, reg_we, reg_re, comm_err;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [15:0] regs [64];
  logic [15:0] model [64];

  int checks = 0, errors = 0, cyc = 0;
  int exp_cyc[$];
  bit exp_w[$];
  logic [6:0] exp_a[$];
  logic [7:0] exp_d[$];
  logic [15:0] exp_dout = 16'h0000;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign reg_rdata = regs[reg_addr[6:1]];

  spi_byte_regslave u_spi_byte_regslave (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata), .comm_err(comm_err));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n && (reg_we || reg_re)) begin
      if (exp_cyc.size() == 0) chk("R3 unexpected strobe", {reg_we, reg_re}, 0);
      else begin
        chk("R2/R3 strobe cycle", cyc, exp_cyc[0]);
        chk("R1 operation", reg_we, exp_w[0]);
        chk("R9 byte address", reg_addr, exp_a[0]);
        if (exp_w[0]) chk("R2 write byte", reg_wdata, exp_d[0]);
        void'(exp_cyc.pop_front()); void'(exp_w.pop_front());
        void'(exp_a.pop_front()); void'(exp_d.pop_front());
      end
      if (reg_we) begin
        if (reg_addr[0]) regs[reg_addr[6:1]][15:8] = reg_wdata;
        else             regs[reg_addr[6:1]][7:0]  = reg_wdata;
      end
    end else if (exp_cyc.size() != 0 && cyc > exp_cyc[0]) begin
      chk("R2/R3 missing strobe", 0, 1);
      void'(exp_cyc.pop_front()); void'(exp_w.pop_front());
      void'(exp_a.pop_front()); void'(exp_d.pop_front());
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic frame(input logic [15:0] w, input int nbits, input bit keep_low, input string req);
    logic [15:0] got = '0;
    if (cs_n) begin cs_n = 0; tick(HALF); end
    chk("R7 oe while selected", miso_oe, 1);
    for (int i = 0; i < nbits; i++) begin
      sclk = 0; mosi = w[15-i];
      tick(HALF);
      got[15-i] = miso;
      sclk = 1;
      if (i == 15) begin
        exp_cyc.push_back(cyc + 4); exp_w.push_back(w[15]);
        exp_a.push_back(w[14:8]);   exp_d.push_back(w[7:0]);
      end
      tick(HALF);
    end
    if (!keep_low) begin cs_n = 1; tick(8); end
    if (nbits == 16) begin
      chk(req, got, exp_dout);
      if (w[15]) begin
        if (w[8]) model[w[14:9]][15:8] = w[7:0];
        else      model[w[14:9]][7:0]  = w[7:0];
        exp_dout = 16'h0000;
      end else exp_dout = model[w[14:9]];
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      regs[i]  = 16'(i * 16'h0101) ^ 16'h5A3C;
      model[i] = regs[i];
    end
    tick(3);
    chk("R10 we in reset", reg_we, 0);
    chk("R10 re in reset", reg_re, 0);
    chk("R10 err in reset", comm_err, 0);
    rst_n = 1; tick(4);
    chk("R7 oe idle", miso_oe, 0);
    frame(16'hA512, 16, 0, "R5 dout after reset");
    frame(16'hA434, 16, 0, "R5 dout after write");
    frame(16'h24FF, 16, 0, "R5 dout after write");
    frame(16'h2500, 16, 0, "R4 read even address");
    frame(16'h0200, 16, 0, "R9 odd address whole word");
    frame(16'h8277, 16, 0, "R4 read word two");
    frame(16'h0300, 16, 0, "R5 dout after write");
    frame(16'h24AA, 16, 0, "R4 read after byte write");
    chk("R3 data ignored", exp_dout, 16'h1234);
    frame(16'h0A00, 16, 1, "R6 chain first");
    frame(16'h8B99, 16, 1, "R6 chain second");
    frame(16'h0A00, 16, 0, "R6 chain third");
    chk("R8 no error on whole words", comm_err, 0);
    frame(16'h0A00, 16, 1, "R6 chain read high byte");
    frame(16'h8400, 7, 0, "R8 partial");
    chk("R8 error set", comm_err, 1);
    frame(16'h3000, 16, 0, "R8 pending word kept");
    chk("R7 oe released", miso_oe, 0);
    frame(16'h0000, 16, 0, "R8 realigned read");
    chk("R8 error sticky", comm_err, 1);
    tick(8);
    chk("R2 strobe queue drained", exp_cyc.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule